// File: doc/BRIEF.md
# Dynamic Register Read Port Selector

This block sits between a set of reservation-station operand slots and a register file that has only a few read ports. Each slot raises an active bit and offers the register tag it wants read. In every cycle the selector looks only at the slots that are active. It packs them, lowest slot index first, onto the lowest-numbered read ports. The chosen tags, a valid bit per port, a grant bit per slot and the port index given to each granted slot all leave the block through one register stage. The packing logic therefore starts and ends at flops and does not set the core clock period.

A slot that gets no grant in a cycle keeps its request asserted and tries again in a later cycle. No fairness is applied: slot 0 always wins over slot 1, and so on. The prefix-rank network that orders the slots comes in two forms, picked by a parameter. One is a ripple chain, which is small. The other is a per-slot population count, which is shallow.

Top module: `rdport_packer`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: `port_vld`, `port_tag`, `gnt` and `gnt_port`.
- R2: The outputs change only at a rising edge. They reflect the `req_act` and `req_tag` values sampled at that edge, so there is exactly one cycle of latency.
- R3: Among the active slots, taken in ascending index order, the k-th one (k counted from 0, with k < NUM_PORT) is granted. Its `gnt_port` field, in bits [i*PIDX_W +: PIDX_W], holds k.
- R4: A valid port k drives on `port_tag[k*TAG_W +: TAG_W]` the tag of the slot that was granted port k.
- R5: At most NUM_PORT slots are granted per cycle. An active slot ranked NUM_PORT or later gets `gnt`=0, and its `gnt_port` field is 0.
- R6: The valid ports are contiguous from port 0. Their number equals min(active count, NUM_PORT). An unused port drives valid 0 and tag 0.
- R7: A slot whose active bit was 0 is never granted, and its `gnt_port` field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_act | input | NUM_REQ | Per-slot request active bit |
| req_tag | input | NUM_REQ*TAG_W | Per-slot register tag, slot i in bits [i*TAG_W +: TAG_W] |
| port_vld | output | NUM_PORT | Registered valid bit per read port |
| port_tag | output | NUM_PORT*TAG_W | Registered tag per read port, port k in bits [k*TAG_W +: TAG_W] |
| gnt | output | NUM_REQ | Registered grant bit per slot |
| gnt_port | output | NUM_REQ*PIDX_W | Registered port index per slot, 0 when not granted |

## Verification
The vector table runs a range of request patterns, and each pattern separates a different class of fault:
- No request at all, and a single request at the lowest slot and at the highest slot, expose offset and end errors.
- Sparse patterns with exactly four active slots confirm that the packing skips inactive slots.
- Patterns with more than four active slots, including all sixteen and alternating groups, show whether the cut-off falls on the fifth active slot.
- Patterns with two and three active slots check that the unused upper ports stay clean.

Directed tests then check that a change at the inputs is not visible before the next edge, and that a reset asserted in the middle of a run clears every output.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
   // Width of a port index field; at least one bit even for a single port.
   function automatic int pidx_width(input int nports);
      return (nports > 1) ? $clog2(nports) : 1;
   endfunction

   // Width of a saturating rank counter that can hold 0..nports.
   function automatic int rank_width(input int nports);
      return $clog2(nports + 1);
   endfunction
endpackage

// File: rtl/rdp_rank.sv
// Per-slot rank: number of active slots below slot i, saturated at NUM_PORT.
module rdp_rank #(
   parameter int NUM_REQ  = 16,
   parameter int NUM_PORT = 4,
   parameter int CNT_W    = 3,
   parameter bit RIPPLE   = 1'b1
) (
   input  logic [NUM_REQ-1:0]       act,
   output logic [NUM_REQ*CNT_W-1:0] rank
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(NUM_PORT);

   generate
      if (RIPPLE) begin : g_ripple
         always_comb begin
            logic [CNT_W-1:0] acc;
            acc  = '0;
            rank = '0;
            for (int i = 0; i < NUM_REQ; i++) begin
               rank[i*CNT_W +: CNT_W] = acc;
               if (act[i] && (acc != SAT))
                  acc = acc + CNT_W'(1);
            end
         end
      end else begin : g_popcnt
         for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
            localparam logic [NUM_REQ-1:0] BELOW = (NUM_REQ'(1) << i) - NUM_REQ'(1);
            int cnt;
            always_comb begin
               cnt = $countones(act & BELOW);
               if (cnt >= NUM_PORT)
                  rank[i*CNT_W +: CNT_W] = SAT;
               else
                  rank[i*CNT_W +: CNT_W] = CNT_W'(cnt);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rdp_port_mux.sv
// One read port: AND-OR select of the single granted slot whose rank is PORT_ID.
module rdp_port_mux #(
   parameter int NUM_REQ = 16,
   parameter int TAG_W   = 7,
   parameter int CNT_W   = 3,
   parameter int PORT_ID = 0
) (
   input  logic [NUM_REQ-1:0]       grant,
   input  logic [NUM_REQ*CNT_W-1:0] rank,
   input  logic [NUM_REQ*TAG_W-1:0] tags,
   output logic                     vld,
   output logic [TAG_W-1:0]         tag
);
   localparam logic [CNT_W-1:0] ME = CNT_W'(PORT_ID);

   always_comb begin
      vld = 1'b0;
      tag = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (grant[i] && (rank[i*CNT_W +: CNT_W] == ME)) begin
            vld = 1'b1;
            tag = tag | tags[i*TAG_W +: TAG_W];
         end
      end
   end
endmodule

// File: rtl/rdport_packer.sv
module rdport_packer #(
   parameter int NUM_REQ  = 16,
   parameter int NUM_PORT = 4,
   parameter int TAG_W    = 7,
   parameter bit RIPPLE   = 1'b1,
   localparam int PIDX_W  = rdp_pkg::pidx_width(NUM_PORT)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_REQ-1:0]        req_act,
   input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
   output logic [NUM_PORT-1:0]       port_vld,
   output logic [NUM_PORT*TAG_W-1:0] port_tag,
   output logic [NUM_REQ-1:0]        gnt,
   output logic [NUM_REQ*PIDX_W-1:0] gnt_port
);
   localparam int CNT_W = rdp_pkg::rank_width(NUM_PORT);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(NUM_PORT);

   generate
      if (NUM_PORT < 1 || NUM_PORT > NUM_REQ) begin : g_bad_ports
         $error("rdport_packer: NUM_PORT must lie in 1..NUM_REQ");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("rdport_packer: TAG_W must be positive");
      end
   endgenerate

   logic [NUM_REQ*CNT_W-1:0]  rank_c;
   logic [NUM_REQ-1:0]        grant_c;
   logic [NUM_PORT-1:0]       vld_c;
   logic [NUM_PORT*TAG_W-1:0] tag_c;
   logic [NUM_REQ*PIDX_W-1:0] pidx_c;

   rdp_rank #(
      .NUM_REQ (NUM_REQ),
      .NUM_PORT(NUM_PORT),
      .CNT_W   (CNT_W),
      .RIPPLE  (RIPPLE)
   ) u_rank (
      .act (req_act),
      .rank(rank_c)
   );

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_gnt
         assign grant_c[i] = req_act[i] && (rank_c[i*CNT_W +: CNT_W] != SAT);
         assign pidx_c[i*PIDX_W +: PIDX_W] =
            grant_c[i] ? rank_c[i*CNT_W +: PIDX_W] : '0;
      end
      for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
         rdp_port_mux #(
            .NUM_REQ(NUM_REQ),
            .TAG_W  (TAG_W),
            .CNT_W  (CNT_W),
            .PORT_ID(p)
         ) u_mux (
            .grant(grant_c),
            .rank (rank_c),
            .tags (req_tag),
            .vld  (vld_c[p]),
            .tag  (tag_c[p*TAG_W +: TAG_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         port_vld <= '0;
         port_tag <= '0;
         gnt      <= '0;
         gnt_port <= '0;
      end else begin
         port_vld <= vld_c;
         port_tag <= tag_c;
         gnt      <= grant_c;
         gnt_port <= pidx_c;
      end
   end
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
   parameter int NUM_REQ  = 16,
   parameter int NUM_PORT = 4,
   parameter int TAG_W    = 7,
   parameter int PIDX_W   = 2
) (
   input logic                      clk,
   input logic                      rst,
   input logic [NUM_REQ-1:0]        req_act,
   input logic [NUM_REQ*TAG_W-1:0]  req_tag,
   input logic [NUM_PORT-1:0]       port_vld,
   input logic [NUM_PORT*TAG_W-1:0] port_tag,
   input logic [NUM_REQ-1:0]        gnt,
   input logic [NUM_REQ*PIDX_W-1:0] gnt_port
);
   p_gnt_limit_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(gnt) <= NUM_PORT);

   p_vld_contig_r6: assert property (@(posedge clk) disable iff (rst)
      $countones({1'b0, port_vld} + (NUM_PORT+1)'(1)) == 1);

   p_cnt_match_r6: assert property (@(posedge clk) disable iff (rst)
      $countones(gnt) == $countones(port_vld));

   p_inactive_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((gnt & ~$past(req_act)) == '0));

   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (port_vld[0] == $past(|req_act)));

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (port_vld == '0 && gnt == '0));

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
         p_tag_r4: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> (port_vld[gnt_port[i*PIDX_W +: PIDX_W]] &&
                        port_tag[gnt_port[i*PIDX_W +: PIDX_W]*TAG_W +: TAG_W]
                        == $past(req_tag[i*TAG_W +: TAG_W])));
      end
   endgenerate
endmodule

bind rdport_packer rdp_checker #(
   .NUM_REQ (NUM_REQ),
   .NUM_PORT(NUM_PORT),
   .TAG_W   (TAG_W),
   .PIDX_W  (PIDX_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .req_act (req_act),
   .req_tag (req_tag),
   .port_vld(port_vld),
   .port_tag(port_tag),
   .gnt     (gnt),
   .gnt_port(gnt_port)
);

// File: tb/sim_rdport_packer.sv
module sim_rdport_packer;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 16;
   localparam int NP = 4;
   localparam int TW = 7;
   localparam int PW = 2;
   localparam int NVEC = 11;

   // {active, expected grant, expected port valid}
   localparam logic [35:0] VEC [NVEC] = '{
      {16'h0000, 16'h0000, 4'h0},
      {16'h0001, 16'h0001, 4'h1},
      {16'h8000, 16'h8000, 4'h1},
      {16'hFFFF, 16'h000F, 4'hF},
      {16'h8421, 16'h8421, 4'hF},
      {16'hA500, 16'hA500, 4'hF},
      {16'hF0F0, 16'h00F0, 4'hF},
      {16'h9248, 16'h1248, 4'hF},
      {16'h0300, 16'h0300, 4'h3},
      {16'h4010, 16'h4010, 4'h3},
      {16'h0E00, 16'h0E00, 4'h7}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NR-1:0]    req_act = '0;
   logic [NR*TW-1:0] req_tag = '0;
   logic [NP-1:0]    port_vld;
   logic [NP*TW-1:0] port_tag;
   logic [NR-1:0]    gnt;
   logic [NR*PW-1:0] gnt_port;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdport_packer u0 (
      .clk(clk), .rst(rst), .req_act(req_act), .req_tag(req_tag),
      .port_vld(port_vld), .port_tag(port_tag), .gnt(gnt), .gnt_port(gnt_port)
   );

   function automatic logic [TW-1:0] tag_of(input int v, input int i);
      return TW'((i * 11 + v * 5 + 3) % 128);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load_tags(input int v);
      for (int i = 0; i < NR; i++) req_tag[i*TW +: TW] = tag_of(v, i);
   endtask

   // Expected port tags and per-slot port indices from the packing rule.
   task automatic expect_ports(input int v, input logic [NR-1:0] a,
                               output logic [NP*TW-1:0] et,
                               output logic [NR*PW-1:0] ep);
      int k;
      k  = 0;
      et = '0;
      ep = '0;
      for (int i = 0; i < NR; i++) begin
         if (a[i] && k < NP) begin
            et[k*TW +: TW] = tag_of(v, i);
            ep[i*PW +: PW] = PW'(k);
            k++;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [NP*TW-1:0] et;
      logic [NR*PW-1:0] ep;
      load_tags(99);
      req_act = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1: reset holds every output at zero even with requests present
      check("R1", "vld in reset", 128'(port_vld), 128'(0));
      check("R1", "gnt in reset", 128'(gnt), 128'(0));
      check("R1", "tags in reset", 128'(port_tag), 128'(0));
      check("R1", "pidx in reset", 128'(gnt_port), 128'(0));
      rst = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         logic [NR-1:0] a;
         a = VEC[v][35:20];
         req_act = a;
         load_tags(v);
         @(negedge clk);
         expect_ports(v, a, et, ep);
         check("R3/R5/R7", $sformatf("gnt vec %0d", v), 128'(gnt), 128'(VEC[v][19:4]));
         check("R6", $sformatf("vld vec %0d", v), 128'(port_vld), 128'(VEC[v][3:0]));
         check("R4/R6", $sformatf("tags vec %0d", v), 128'(port_tag), 128'(et));
         check("R3/R5", $sformatf("pidx vec %0d", v), 128'(gnt_port), 128'(ep));
      end

      // R2: new inputs are invisible until the next rising edge
      req_act = 16'h0002;
      load_tags(20);
      @(negedge clk);
      req_act = 16'h0000;
      #1;
      check("R2", "vld before edge", 128'(port_vld), 128'(4'h1));
      check("R2", "tag before edge", 128'(port_tag[TW-1:0]), 128'(tag_of(20, 1)));
      @(negedge clk);
      check("R2", "vld after edge", 128'(port_vld), 128'(0));

      // R5: fifth active slot (index 15) gets no grant and port index 0
      req_act = 16'h800F;
      load_tags(21);
      @(negedge clk);
      check("R5", "slot15 gnt", 128'(gnt[15]), 128'(0));
      check("R5", "slot15 pidx", 128'(gnt_port[15*PW +: PW]), 128'(0));
      check("R3", "slot3 pidx", 128'(gnt_port[3*PW +: PW]), 128'(3));

      // R1: reset in mid-run clears the outputs
      req_act = 16'hFFFF;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1", "vld after mid reset", 128'(port_vld), 128'(0));
      check("R1", "gnt after mid reset", 128'(gnt), 128'(0));
      rst = 1'b0;
      @(negedge clk);
      check("R1", "recover after reset", 128'(gnt), 128'(16'h000F));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule